// File: doc/BRIEF.md
# Infrared Carrier Clock Divider and Modulator

This block produces the timing for an infrared transmitter. A divide-by-two enable paces a 16-bit down counter. The counter reloads from a programmable divider value whenever it passes zero. It also reloads whenever that value is rewritten. Each zero crossing emits a single-cycle tick, which is the transmit clock that feeds the carrier sequencer and any downstream pulse-width timer.

The carrier sequencer splits one carrier period into sixteen ticks. A 4-bit duty setting chooses how many leading ticks of the period are high; the rest of the period is low. When modulation is on, a mark sends bursts of this carrier and a space keeps the line low. Each new mark restarts the carrier at its first high tick. When modulation is off, the line copies the mark/space level and the duty setting has no effect. The output line is registered.

Top module: `ir_carrier_mod`

## Requirements
- R1: After reset, `tick` and `ir_out` are low and the divider value is 0xFFFF. With no write, the first tick appears 131072 cycles after reset is released.
- R2: `tick` is high for exactly one cycle at a time. With divider value D it recurs every 2*(D+1) cycles.
- R3: A write of divider value D reloads the counter at once and suppresses any tick in the following cycle. The first tick comes 2*D+2 cycles after the clock edge that samples `div_wr`.
- R4: Writing 0x0000 to the divider gives the same result as writing 0x0001.
- R5: With modulation on and a mark held, one carrier period lasts 16 ticks, or 32*(D+1) cycles. The carrier phase moves only on a tick.
- R6: With modulation on and duty code N (0..14), each carrier period has one high run of N+1 ticks, then a low run of 15-N ticks. That is 2*(D+1)*(N+1) high cycles per period, with one rising edge per period.
- R7: With modulation on, a new mark starts with the high portion: `ir_out` is high in the cycle after `mark` rises.
- R8: With modulation on and a space (`mark` low), `ir_out` is low in the following cycle and has no transitions.
- R9: With modulation off, `ir_out` equals the value `mark` had one cycle earlier, whatever the duty code.
- R10: With modulation on, duty code 15 holds `ir_out` high for the whole mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_wr | input | 1 | Write strobe for the divider value |
| div_val | input | 16 | Divider value; 0 is taken as 1 |
| duty | input | 4 | Carrier duty code N: N+1 high ticks out of 16 |
| mod_en | input | 1 | 1 sends marks as carrier bursts; 0 passes the level straight through |
| mark | input | 1 | Level to send: 1 = mark, 0 = space |
| tick | output | 1 | Single-cycle transmit clock pulse |
| ir_out | output | 1 | Registered infrared output line |

## Verification
The first tick after a write is due 2*D+2 cycles after the edge that samples the strobe. After that, ticks are due every 2*(D+1) cycles. The bench counts negedges from the write edge and compares the count with those numbers. `ir_out` changes one cycle after `mark` or `mod_en`, so level checks sample at the next negedge. Carrier duty is judged over a window of exactly one carrier period, 32*(D+1) cycles, opened after the burst has settled. That makes the high-cycle count, rising-edge count and tick count independent of where the tick phase falls against the mark.

// File: rtl/ir_carrier_pkg.sv
package ir_carrier_pkg;
    localparam int IRC_DIV_W   = 16;
    localparam int IRC_PHASE_W = 4;

    // A zero divider value is mapped to one so the counter never stalls.
    function automatic logic [IRC_DIV_W-1:0] irc_fix_div(input logic [IRC_DIV_W-1:0] v);
        return (v == '0) ? IRC_DIV_W'(1) : v;
    endfunction
endpackage

// File: rtl/ir_tick_div.sv
module ir_tick_div
    import ir_carrier_pkg::*;
#(
    parameter int DIV_W = IRC_DIV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [DIV_W-1:0] val_i,
    output logic             tick_o
);
    localparam logic [DIV_W-1:0] DIV_RST  = '1;
    localparam logic [DIV_W-1:0] DIV_ZERO = '0;
    localparam logic [DIV_W-1:0] DIV_ONE  = DIV_W'(1);

    typedef struct packed {
        logic             half;
        logic [DIV_W-1:0] load;
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [DIV_W-1:0] wr_fixed;

    always_comb begin
        wr_fixed = (val_i == DIV_ZERO) ? DIV_ONE : val_i;
        st_d      = st_q;
        st_d.tick = 1'b0;
        st_d.half = ~st_q.half;
        if (wr_i) begin
            st_d.load = wr_fixed;
            st_d.cnt  = wr_fixed;
            st_d.half = 1'b0;
        end else if (st_q.half) begin
            if (st_q.cnt == DIV_ZERO) begin
                st_d.cnt  = st_q.load;
                st_d.tick = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - DIV_ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.half <= 1'b0;
            st_q.load <= DIV_RST;
            st_q.cnt  <= DIV_RST;
            st_q.tick <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;
endmodule

// File: rtl/ir_carrier_seq.sv
module ir_carrier_seq
    import ir_carrier_pkg::*;
#(
    parameter int PH_W = IRC_PHASE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            mark_i,
    input  logic [PH_W-1:0] duty_i,
    output logic [PH_W-1:0] phase_o,
    output logic            hi_o
);
    localparam logic [PH_W-1:0] PH_ONE = PH_W'(1);

    typedef struct packed {
        logic [PH_W-1:0] phase;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!mark_i) begin
            st_d.phase = '0;
        end else if (tick_i) begin
            st_d.phase = st_q.phase + PH_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;
    assign hi_o    = (st_q.phase <= duty_i);
endmodule

// File: rtl/ir_out_stage.sv
module ir_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic mod_en_i,
    input  logic mark_i,
    input  logic carrier_hi_i,
    output logic line_o
);
    typedef struct packed {
        logic line;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mod_en_i) begin
            st_d.line = mark_i & carrier_hi_i;
        end else begin
            st_d.line = mark_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.line <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_o = st_q.line;
endmodule

// File: rtl/ir_carrier_mod.sv
module ir_carrier_mod
    import ir_carrier_pkg::*;
#(
    parameter int DIV_W = IRC_DIV_W,
    parameter int PH_W  = IRC_PHASE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_val,
    input  logic [PH_W-1:0]  duty,
    input  logic             mod_en,
    input  logic             mark,
    output logic             tick,
    output logic             ir_out
);
    logic [PH_W-1:0] phase_w;
    logic            hi_w;

    ir_tick_div #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (div_wr),
        .val_i  (div_val),
        .tick_o (tick)
    );

    ir_carrier_seq #(.PH_W(PH_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick),
        .mark_i  (mark),
        .duty_i  (duty),
        .phase_o (phase_w),
        .hi_o    (hi_w)
    );

    ir_out_stage u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .mod_en_i     (mod_en),
        .mark_i       (mark),
        .carrier_hi_i (hi_w),
        .line_o       (ir_out)
    );
endmodule

// File: rtl/ir_carrier_mod_chk.sv
module ir_carrier_mod_chk #(
    parameter int PH_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            div_wr,
    input logic            mod_en,
    input logic            mark,
    input logic            tick,
    input logic            ir_out,
    input logic [PH_W-1:0] phase
);
    // R2
    tick_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R3
    write_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr |=> !tick);

    // R5
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mark && !tick) |=> (phase == $past(phase)));

    // R7
    burst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && $rose(mark)) |=> ir_out);

    // R8
    space_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && !mark) |=> !ir_out);

    // R9
    bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |=> (ir_out == $past(mark)));
endmodule

bind ir_carrier_mod ir_carrier_mod_chk #(.PH_W(PH_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .div_wr (div_wr),
    .mod_en (mod_en),
    .mark   (mark),
    .tick   (tick),
    .ir_out (ir_out),
    .phase  (phase_w)
);

// File: tb/ir_carrier_mod_tb.sv
module ir_carrier_mod_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        div_wr = 1'b0;
    logic [15:0] div_val = '0;
    logic [3:0]  duty = '0;
    logic        mod_en = 1'b0;
    logic        mark = 1'b0;
    logic        tick;
    logic        ir_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ir_carrier_mod u_dut (
        .clk(clk), .rst_n(rst_n), .div_wr(div_wr), .div_val(div_val),
        .duty(duty), .mod_en(mod_en), .mark(mark), .tick(tick), .ir_out(ir_out)
    );

    typedef struct packed {
        logic [15:0] wval;
        logic [15:0] deff;
        logic [3:0]  dcode;
        logic        modon;
        logic        lvl;
        logic [15:0] exp_high;
        logic [7:0]  exp_rises;
    } vec_t;

    // exp_high = 2*(D+1)*(N+1) when modulated, full window (32*(D+1)) when bypassed, 0 on space
    localparam vec_t VECS [8] = '{
        '{16'd1, 16'd1, 4'd0,  1'b1, 1'b1, 16'd4,   8'd1},  // R6 narrowest duty
        '{16'd2, 16'd2, 4'd7,  1'b1, 1'b1, 16'd48,  8'd1},  // R6 half duty
        '{16'd4, 16'd4, 4'd14, 1'b1, 1'b1, 16'd150, 8'd1},  // R6 widest gated duty
        '{16'd3, 16'd3, 4'd15, 1'b1, 1'b1, 16'd128, 8'd0},  // R10 steady high
        '{16'd0, 16'd1, 4'd1,  1'b1, 1'b1, 16'd8,   8'd1},  // R4 zero acts as one
        '{16'd1, 16'd1, 4'd3,  1'b0, 1'b1, 16'd64,  8'd0},  // R9 duty ignored
        '{16'd2, 16'd2, 4'd5,  1'b1, 1'b0, 16'd0,   8'd0},  // R8 space stays low
        '{16'd1, 16'd1, 4'd9,  1'b0, 1'b0, 16'd0,   8'd0}   // R9 bypassed space
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_div(input logic [15:0] v);
        @(negedge clk);
        div_val = v;
        div_wr  = 1'b1;
        @(negedge clk);
        div_wr  = 1'b0;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n;
        int first;
        int high;
        int rises;
        int ticks;
        logic prev;

        // R1 reset state
        repeat (3) @(negedge clk);
        check(tick == 1'b0, "R1 tick in reset", tick, 0);
        check(ir_out == 1'b0, "R1 ir_out in reset", ir_out, 0);
        rst_n = 1'b1;
        n = 0;
        first = 0;
        while (first == 0 && n < 140000) begin
            @(negedge clk);
            n++;
            if (tick) first = n;
        end
        check(first == 131072, "R1 first tick after reset", first, 131072);

        // R3 reload on write with D=3, R2 width and period
        write_div(16'd3);
        n = 0;
        first = 0;
        while (first == 0 && n < 40) begin
            @(negedge clk);
            n++;
            if (tick) first = n;
        end
        check(first == 8, "R3 first tick after write", first, 8);
        @(negedge clk);
        check(tick == 1'b0, "R2 tick one cycle wide", tick, 0);
        n = 1;
        first = 0;
        while (first == 0 && n < 40) begin
            @(negedge clk);
            n++;
            if (tick) first = n;
        end
        check(first == 8, "R2 tick period D=3", first, 8);

        // R3 rewrite in mid-count
        repeat (3) @(negedge clk);
        write_div(16'd5);
        n = 0;
        first = 0;
        while (first == 0 && n < 40) begin
            @(negedge clk);
            n++;
            if (tick) first = n;
        end
        check(first == 12, "R3 rewrite restarts count", first, 12);

        // R4 zero written
        write_div(16'd0);
        n = 0;
        first = 0;
        while (first == 0 && n < 40) begin
            @(negedge clk);
            n++;
            if (tick) first = n;
        end
        check(first == 4, "R4 zero divider first tick", first, 4);

        // Vector table: one carrier period window per entry (R5, R6, R8, R9, R10)
        foreach (VECS[i]) begin
            @(negedge clk);
            div_val = VECS[i].wval;
            div_wr  = 1'b1;
            duty    = VECS[i].dcode;
            mod_en  = VECS[i].modon;
            mark    = VECS[i].lvl;
            @(negedge clk);
            div_wr  = 1'b0;
            repeat (40 * (int'(VECS[i].deff) + 1) + 8) @(negedge clk);
            prev  = ir_out;
            high  = 0;
            rises = 0;
            ticks = 0;
            for (int k = 0; k < 32 * (int'(VECS[i].deff) + 1); k++) begin
                @(negedge clk);
                if (ir_out) high++;
                if (ir_out && !prev) rises++;
                if (tick) ticks++;
                prev = ir_out;
            end
            check(high == int'(VECS[i].exp_high), $sformatf("R6 vec%0d high cycles", i),
                  high, int'(VECS[i].exp_high));
            check(rises == int'(VECS[i].exp_rises), $sformatf("R6 vec%0d rising edges", i),
                  rises, int'(VECS[i].exp_rises));
            check(ticks == 16, $sformatf("R5 vec%0d ticks per period", i), ticks, 16);
        end

        // R7 / R8 burst restart with D=5, N=3
        write_div(16'd5);
        @(negedge clk);
        duty   = 4'd3;
        mod_en = 1'b1;
        mark   = 1'b1;
        repeat (100) @(negedge clk);
        mark = 1'b0;
        @(negedge clk);
        check(ir_out == 1'b0, "R8 space goes low", ir_out, 0);
        repeat (7) @(negedge clk);
        check(ir_out == 1'b0, "R8 space stays low", ir_out, 0);
        mark = 1'b1;
        @(negedge clk);
        check(ir_out == 1'b1, "R7 burst starts high", ir_out, 1);

        // R9 bypass follows mark one cycle later
        mod_en = 1'b0;
        duty   = 4'd0;
        mark   = 1'b0;
        @(negedge clk);
        check(ir_out == 1'b0, "R9 bypass low", ir_out, 0);
        mark = 1'b1;
        @(negedge clk);
        check(ir_out == 1'b1, "R9 bypass high", ir_out, 1);
        repeat (30) @(negedge clk);
        check(ir_out == 1'b1, "R9 bypass holds despite duty", ir_out, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule